// File: doc/BRIEF.md
# Snapshot Clock-Cycle Counter Unit

This unit keeps a wide free-running cycle count and a software-visible copy of it. The master counter advances on every clock when the count-mode input is 1. When that input is 0 it advances only on clocks where the processor is not stalled. Software never reads the master directly. It reads a snapshot register that takes the master value only at reset and when an interruptible jump retires successfully. Between two such jumps, a read of the low word and a read of the high word therefore come from the same sample.

Two read operations select the lower or the upper half of the snapshot. The selected word is sent to a destination write port. A read may carry a guard. When it does, the destination is written only if the guard's least-significant bit is 1. An unguarded read always writes. The result and its write enable are registered, so they appear one cycle after the read is issued.

Top module: `cycle_snap_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, the master and the snapshot are both zero. During reset, res_we_o is 0 and res_o is 0.
- R2: When cnt_all_i is 1, the master increments on every clock, whether or not stall_i is high.
- R3: When cnt_all_i is 0, the master increments only on clocks where stall_i is 0. Otherwise it holds.
- R4: The snapshot takes the master value only on a clock where jmp_retire_i is 1. On every other clock it holds its value.
- R5: When jmp_retire_i is high on a clock that also increments the master, the snapshot captures the master value from before that increment.
- R6: op_i = 1 is the low-word read. It returns snapshot bits WORD_W-1:0.
- R7: op_i = 2 is the high-word read. It returns snapshot bits 2*WORD_W-1:WORD_W. For example, a snapshot of 0xabcdefff12345678 returns 0xabcdefff. op_i = 0 or 3 issues no read, and res_we_o stays 0.
- R8: When guarded_i is 1 and guard_lsb_i is 0, the read does not write: res_we_o is 0 and res_o keeps its previous value. When guarded_i is 1 and guard_lsb_i is 1, the read writes.
- R9: When guarded_i is 0, a read always writes (res_we_o is 1).
- R10: res_o and res_we_o appear one clock after the read is issued. res_o carries the snapshot value from the issue cycle, even if a jump retires in that same cycle.
- R11: The master wraps from all-ones to zero and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stall_i | input | 1 | Processor stalled this cycle |
| cnt_all_i | input | 1 | Count mode: 1 counts every cycle, 0 counts only non-stalled cycles |
| jmp_retire_i | input | 1 | A successful interruptible jump retires this cycle |
| op_i | input | 2 | Read select: 0 none, 1 low word, 2 high word, 3 none |
| guarded_i | input | 1 | The read carries a guard |
| guard_lsb_i | input | 1 | Least-significant bit of the guard operand |
| res_o | output | WORD_W | Result word for the destination |
| res_we_o | output | 1 | Destination write enable |

## Verification
A read's word and its write enable are due one clock after issue. The bench drives each read at a falling edge, lets one rising edge pass, and compares at the next falling edge. The master value is never seen directly. It shows up only through a later jump-retire capture followed by a read, which is at least two clocks later, and the expected words in the vector table are worked out along that chain. Wrap-around and a non-zero high word are tested on a second instance with 4-bit words. That instance counts on every cycle, so its master equals the number of clock edges since its reset was released, modulo 256.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_RD_LO = 2'd1,
    OP_RD_HI = 2'd2,
    OP_RSVD  = 2'd3
  } ccu_op_e;
endpackage

// File: rtl/ccu_master_ctr.sv
module ccu_master_ctr #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stall_i,
  input  logic             cnt_all_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic             cnt_en;
  logic [CNT_W-1:0] cnt_d, cnt_q;

  always_comb begin
    cnt_en = cnt_all_i | ~stall_i;
    cnt_d  = cnt_q;
    if (cnt_en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R2: all-cycle mode advances even when stalled
  a_r2_count_all: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_all_i |=> cnt_q == $past(cnt_q) + 1'b1);
  // R3: stall-excluding mode holds on stalled cycles
  a_r3_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_all_i && stall_i) |=> $stable(cnt_q));
  // R3: stall-excluding mode advances on free cycles
  a_r3_count_free: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_all_i && !stall_i) |=> cnt_q == $past(cnt_q) + 1'b1);
  // R11: silent wrap to zero
  a_r11_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == '1 && (cnt_all_i || !stall_i)) |=> cnt_q == '0);
endmodule

// File: rtl/ccu_snap_reg.sv
module ccu_snap_reg #(
  parameter int CNT_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] master_i,
  output logic [CNT_W-1:0] snap_o
);
  logic [CNT_W-1:0] snap_d, snap_q;

  always_comb begin
    snap_d = snap_q;
    if (load_i) snap_d = master_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) snap_q <= '0;
    else        snap_q <= snap_d;
  end

  assign snap_o = snap_q;

  // R4: holds without a retiring jump
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load_i |=> $stable(snap_q));
  // R5: captures the pre-increment master value
  a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> snap_q == $past(master_i));
endmodule

// File: rtl/ccu_rd_port.sv
module ccu_rd_port
  import ccu_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int CNT_W = 2 * WORD_W,
  localparam int NUM_WORDS = CNT_W / WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ccu_op_e           op_i,
  input  logic              guarded_i,
  input  logic              guard_lsb_i,
  input  logic [CNT_W-1:0]  snap_i,
  output logic [WORD_W-1:0] res_o,
  output logic              we_o
);
  logic [WORD_W-1:0] words [NUM_WORDS];
  logic              is_read, we_d;
  logic [WORD_W-1:0] res_d, res_q;
  logic              we_q;

  for (genvar gi = 0; gi < NUM_WORDS; gi++) begin : g_word
    assign words[gi] = snap_i[gi*WORD_W +: WORD_W];
  end

  always_comb begin
    is_read = (op_i == OP_RD_LO) || (op_i == OP_RD_HI);
    we_d    = is_read && (!guarded_i || guard_lsb_i);
    res_d   = res_q;
    if (we_d) res_d = (op_i == OP_RD_HI) ? words[1] : words[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      we_q  <= 1'b0;
    end else begin
      res_q <= res_d;
      we_q  <= we_d;
    end
  end

  assign res_o = res_q;
  assign we_o  = we_q;

  // R8: a false guard blocks the write and keeps the result
  a_r8_guard_block: assert property (@(posedge clk) disable iff (!rst_n)
    (guarded_i && !guard_lsb_i) |=> (!we_o && $stable(res_o)));
  // R9: an unguarded read always writes
  a_r9_unguarded: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_i == OP_RD_LO || op_i == OP_RD_HI) && !guarded_i) |=> we_o);
  // R10: low read returns the issue-cycle word one clock later
  a_r10_lo_value: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_RD_LO && (!guarded_i || guard_lsb_i)) |=> res_o == $past(snap_i[WORD_W-1:0]));
  // R7: no read issued means no write
  a_r7_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_NONE || op_i == OP_RSVD) |=> !we_o);
endmodule

// File: rtl/cycle_snap_unit.sv
module cycle_snap_unit
  import ccu_pkg::*;
#(
  parameter int WORD_W = 32,
  localparam int CNT_W = 2 * WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              cnt_all_i,
  input  logic              jmp_retire_i,
  input  logic [1:0]        op_i,
  input  logic              guarded_i,
  input  logic              guard_lsb_i,
  output logic [WORD_W-1:0] res_o,
  output logic              res_we_o
);
  logic [CNT_W-1:0] master;
  logic [CNT_W-1:0] snap;
  ccu_op_e          op;

  assign op = ccu_op_e'(op_i);

  ccu_master_ctr #(.CNT_W(CNT_W)) u_master (
    .clk       (clk),
    .rst_n     (rst_n),
    .stall_i   (stall_i),
    .cnt_all_i (cnt_all_i),
    .cnt_o     (master)
  );

  ccu_snap_reg #(.CNT_W(CNT_W)) u_snap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_i   (jmp_retire_i),
    .master_i (master),
    .snap_o   (snap)
  );

  ccu_rd_port #(.WORD_W(WORD_W)) u_rd (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op),
    .guarded_i   (guarded_i),
    .guard_lsb_i (guard_lsb_i),
    .snap_i      (snap),
    .res_o       (res_o),
    .we_o        (res_we_o)
  );

  // R1: the first cycle after reset sees a zero snapshot
  a_r1_reset_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (snap == '0 && master == '0));
endmodule

// File: tb/tb_cycle_snap_unit.sv
module tb_cycle_snap_unit;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // main instance, 32-bit words
  logic rst_n, stall, cnt_all, jmp, gd, g0;
  logic [1:0]  op;
  logic [31:0] res;
  logic        we;

  cycle_snap_unit #(.WORD_W(32)) dut (
    .clk(clk), .rst_n(rst_n), .stall_i(stall), .cnt_all_i(cnt_all),
    .jmp_retire_i(jmp), .op_i(op), .guarded_i(gd), .guard_lsb_i(g0),
    .res_o(res), .res_we_o(we)
  );

  // narrow instance, 4-bit words (8-bit master) for wrap and high word
  logic       w_rst_n, w_jmp;
  logic [1:0] w_op;
  logic [3:0] w_res;
  logic       w_we;

  cycle_snap_unit #(.WORD_W(4)) dut_w (
    .clk(clk), .rst_n(w_rst_n), .stall_i(1'b1), .cnt_all_i(1'b1),
    .jmp_retire_i(w_jmp), .op_i(w_op), .guarded_i(1'b0), .guard_lsb_i(1'b0),
    .res_o(w_res), .res_we_o(w_we)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  // {stall, cnt_all, jmp, op[1:0], gd, g0, exp_we, exp_res[31:0]}
  localparam int NV = 9;
  localparam logic [39:0] VEC [NV] = '{
    {1'b0,1'b0,1'b0,2'd0,1'b0,1'b0, 1'b0, 32'd0}, // R7 idle; R3 counts -> 1
    {1'b1,1'b0,1'b0,2'd1,1'b0,1'b0, 1'b1, 32'd0}, // R9 R6 read 0; R3 stall holds 1
    {1'b1,1'b1,1'b1,2'd0,1'b0,1'b0, 1'b0, 32'd0}, // R5 snap=1; R2 stalled count -> 2
    {1'b0,1'b0,1'b0,2'd1,1'b1,1'b1, 1'b1, 32'd1}, // R8 guard true; master -> 3
    {1'b1,1'b0,1'b1,2'd2,1'b0,1'b0, 1'b1, 32'd0}, // R7 high word 0; snap=3
    {1'b0,1'b1,1'b0,2'd1,1'b1,1'b0, 1'b0, 32'd0}, // R8 guard false keeps 0; master -> 4
    {1'b1,1'b1,1'b0,2'd1,1'b0,1'b0, 1'b1, 32'd3}, // R4 held at 3; master -> 5
    {1'b0,1'b0,1'b1,2'd1,1'b0,1'b0, 1'b1, 32'd3}, // R10 issue value; snap=5
    {1'b0,1'b0,1'b0,2'd1,1'b0,1'b0, 1'b1, 32'd5}  // R4 new snapshot visible
  };

  task automatic w_step(logic j, logic [1:0] o);
    w_jmp = j; w_op = o;
    @(posedge clk); @(negedge clk);
    w_jmp = 1'b0; w_op = 2'd0;
  endtask

  initial begin
    #3_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    int edges;
    rst_n = 1'b0; stall = 1'b0; cnt_all = 1'b0; jmp = 1'b0;
    op = 2'd0; gd = 1'b0; g0 = 1'b0;
    w_rst_n = 1'b0; w_jmp = 1'b0; w_op = 2'd0;
    repeat (3) @(negedge clk);
    check("R1 reset res", res, 32'd0);
    check("R1 reset we", {31'd0, we}, 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      {stall, cnt_all, jmp, op, gd, g0} = VEC[i][39:33];
      @(posedge clk); @(negedge clk);
      check($sformatf("vec%0d we", i), {31'd0, we}, {31'd0, VEC[i][32]});
      check($sformatf("vec%0d res", i), res, VEC[i][31:0]);
    end
    {stall, cnt_all, jmp, op, gd, g0} = '0;

    // R1: mid-run reset clears the snapshot; read right after release
    rst_n = 1'b0;
    #1;
    check("R1 async clear we", {31'd0, we}, 32'd0);
    check("R1 async clear res", res, 32'd0);
    @(negedge clk);
    rst_n = 1'b1; op = 2'd2;
    @(posedge clk); @(negedge clk);
    op = 2'd0;
    check("R1 snapshot zero after reset", res, 32'd0);

    // narrow instance: master equals edges since release
    w_rst_n = 1'b1;
    edges = 0;
    while (edges < 8'h5A) begin w_step(1'b0, 2'd0); edges++; end
    w_step(1'b1, 2'd0); edges++;          // snapshot = 0x5A
    w_step(1'b0, 2'd2); edges++;
    check("R7 high word", {28'd0, w_res}, 32'h5);
    w_step(1'b0, 2'd1); edges++;
    check("R6 low word", {28'd0, w_res}, 32'hA);
    while (edges < 255) begin w_step(1'b0, 2'd0); edges++; end
    w_step(1'b1, 2'd2); edges++;          // capture 0xFF, read shows old 0x5A high
    check("R10 high read at issue", {28'd0, w_res}, 32'h5);
    w_step(1'b1, 2'd2); edges++;          // capture wrapped 0
    check("R11 before wrap high", {28'd0, w_res}, 32'hF);
    w_step(1'b0, 2'd1); edges++;
    check("R11 wrapped low", {28'd0, w_res}, 32'h0);
    w_step(1'b0, 2'd2); edges++;
    check("R11 wrapped high", {28'd0, w_res}, 32'h0);
    check("R9 narrow we", {31'd0, w_we}, 32'd1);

    done = 1'b1;
    finish_run();
  end
endmodule